// File: doc/BRIEF.md
# SCSI Initiator Information-Transfer Sequencer

This block runs the initiator side of one asynchronous information-transfer command on a SCSI bus. It samples the target's phase lines and REQ, answers each byte with ACK, drives ATN, moves bytes between the bus and local byte queues, and counts bytes against a programmed length. When the command ends, it raises a service-request interrupt or a successful-operation interrupt. A bus-reset command can abort any activity at any time.

The phase input is `{MSG, C/D, I/O}`, with all bus signals active high inside the block. The encodings are Data-Out 000, Data-In 001, Command 010, Status 011, Message-Out 110 and Message-In 111. Bit 0 (I/O) set means the byte travels into the initiator. Command codes are decoded on bits 6:0: 10h is a transfer and 03h is a bus reset. Bit 7 selects the counted variant of a transfer (90h).

States: `S_IDLE`, `S_WAIT_REQ`, `S_SETTLE`, `S_DRIVE`, `S_ACK_WAIT`, `S_WAIT_SVC`, `S_HOLD_ACK`, `S_BUS_RST`. Transitions:
- IDLE/HOLD_ACK→WAIT_REQ on an accepted transfer.
- WAIT_REQ→SETTLE on REQ in the locked phase.
- WAIT_REQ→WAIT_SVC on a phase mismatch.
- SETTLE→DRIVE always.
- DRIVE→ACK_WAIT always, raising ACK.
- ACK_WAIT→WAIT_REQ when REQ falls on a non-final byte.
- ACK_WAIT→WAIT_SVC when REQ falls on the final byte.
- ACK_WAIT→HOLD_ACK when REQ falls on the final Message-In byte.
- WAIT_SVC→IDLE on REQ.
- any→BUS_RST on a reset command.
- BUS_RST→IDLE after `RST_CYC` cycles.

Top module: `scsi_xfer_seq`

## Requirements
- R1: After reset, ack_o, atn_o, bus_rst_o, all interrupts, par_err_o, illegal_o and busy_o are 0, and cmd_reg_o is 00h.
- R2: Each byte uses a four-edge handshake. ACK rises only after REQ is seen in the locked phase, and ACK falls only after REQ is seen low. Input bytes are pushed to the receive queue with the bus value. Output bytes are popped from the transmit queue and driven with dat_oe_o high while ACK is asserted.
- R3: Code 90h transfers exactly xfer_len_i bytes. Code 10h ends an output phase when the transmit queue is empty after a pop, and moves one byte in an input phase. After the final byte (except in Message-In), irq_svc_o rises when the target next raises REQ.
- R4: Each output byte carries odd parity: dat_o together with dpar_o holds an odd number of ones.
- R5: With par_chk_en_i high, an input byte with even total ones sets the sticky par_err_o. With par_chk_en_i low, par_err_o stays 0.
- R6: In Data-In (001), a parity error with checking enabled raises atn_o before ACK is released for that byte.
- R7: A transfer started in Message-Out (110) raises atn_o. For the final byte, atn_o falls at least one cycle before ACK rises.
- R8: On the final Message-In (111) byte, ACK stays high after REQ falls, irq_done_o rises, irq_svc_o stays 0 and busy_o drops. The next accepted command releases ACK.
- R9: If the phase lines leave the locked phase before the count is reached, cmd_reg_o clears at once, no further byte is moved, and irq_svc_o rises on the next REQ.
- R10: Code 03h or 83h, in any state, drops ACK and ATN and drives bus_rst_o for RST_CYC cycles. It sets irq_rst_o unless rst_irq_dis_i is high.
- R11: A command other than a reset that arrives while busy_o is high, and any unknown code, is ignored and sets illegal_o. Neither cmd_reg_o nor the byte count changes.
- R12: An accepted transfer clears irq_svc_o, irq_done_o, irq_rst_o, par_err_o and illegal_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | 1 | Command strobe, one cycle |
| cmd_code_i | input | 8 | Command code |
| xfer_len_i | input | CNT_W | Byte count for the counted variant |
| par_chk_en_i | input | 1 | Enable input parity checking |
| rst_irq_dis_i | input | 1 | Suppress the bus-reset interrupt |
| phase_i | input | 3 | {MSG, C/D, I/O} from the target |
| req_i | input | 1 | REQ from the target |
| ack_o | output | 1 | ACK to the target |
| atn_o | output | 1 | ATN to the target |
| bus_rst_o | output | 1 | Bus reset drive |
| dat_i | input | 8 | Bus data in |
| dpar_i | input | 1 | Bus parity in |
| dat_o | output | 8 | Bus data out |
| dpar_o | output | 1 | Bus parity out |
| dat_oe_o | output | 1 | Bus data drive enable |
| tx_dat_i | input | 8 | Head of transmit queue |
| tx_empty_i | input | 1 | Transmit queue empty |
| tx_pop_o | output | 1 | Pop transmit queue |
| rx_dat_o | output | 8 | Byte to receive queue |
| rx_push_o | output | 1 | Push receive queue |
| irq_svc_o | output | 1 | Service-request interrupt |
| irq_done_o | output | 1 | Successful-operation interrupt |
| irq_rst_o | output | 1 | Bus-reset interrupt |
| busy_o | output | 1 | A command is in progress |
| cmd_reg_o | output | 8 | Current command, 00h when cleared |
| par_err_o | output | 1 | Sticky parity error |
| illegal_o | output | 1 | Sticky illegal command |

## Verification
The sequencer is driven in counted Data-In, uncounted Data-Out, counted Message-Out and uncounted Message-In and Status transfers. Together these separate the two last-byte rules and the three ending behaviours: a later service request, a held ACK, and ATN dropping ahead of ACK. Input bytes with deliberately wrong parity are sent with checking on and then off, in Data-In, to split the status effect from the ATN effect. A phase switch in mid-count, a command during a transfer and an unknown code show that the command clears and that intruding commands are ignored. A reset issued in the middle of a byte, with and without the interrupt suppressed, checks the abort path.

// File: rtl/scsi_xfer_pkg.sv
package scsi_xfer_pkg;

    localparam logic [2:0] PH_DOUT = 3'b000;
    localparam logic [2:0] PH_DIN  = 3'b001;
    localparam logic [2:0] PH_CMD  = 3'b010;
    localparam logic [2:0] PH_STAT = 3'b011;
    localparam logic [2:0] PH_MOUT = 3'b110;
    localparam logic [2:0] PH_MIN  = 3'b111;

    localparam logic [6:0] OP_XFER = 7'h10;
    localparam logic [6:0] OP_BRST = 7'h03;

    typedef enum logic [2:0] {
        S_IDLE,
        S_WAIT_REQ,
        S_SETTLE,
        S_DRIVE,
        S_ACK_WAIT,
        S_WAIT_SVC,
        S_HOLD_ACK,
        S_BUS_RST
    } state_e;

    typedef enum logic [1:0] {
        CK_NONE,
        CK_XFER,
        CK_BRST,
        CK_BAD
    } cmd_kind_e;

endpackage

// File: rtl/scsi_xfer_decode.sv
module scsi_xfer_decode
    import scsi_xfer_pkg::*;
(
    input  logic        valid_i,
    input  logic [7:0]  code_i,
    output cmd_kind_e   kind_o,
    output logic        dma_o
);
    always_comb begin
        dma_o = code_i[7];
        if (!valid_i)                   kind_o = CK_NONE;
        else if (code_i[6:0] == OP_XFER) kind_o = CK_XFER;
        else if (code_i[6:0] == OP_BRST) kind_o = CK_BRST;
        else                            kind_o = CK_BAD;
    end
endmodule

// File: rtl/scsi_xfer_parity.sv
module scsi_xfer_parity (
    input  logic [7:0] gen_dat_i,
    output logic       gen_par_o,
    input  logic [7:0] chk_dat_i,
    input  logic       chk_par_i,
    output logic       chk_bad_o
);
    // odd parity: data plus parity bit hold an odd number of ones
    assign gen_par_o = ~(^gen_dat_i);
    assign chk_bad_o = ~(^{chk_dat_i, chk_par_i});
endmodule

// File: rtl/scsi_xfer_cnt.sv
module scsi_xfer_cnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    input  logic         dec_i,
    output logic         one_o
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (load_i) cnt_q <= load_val_i;
        else if (dec_i)  cnt_q <= cnt_q - W'(1);
    end

    assign one_o = (cnt_q == W'(1));
endmodule

// File: rtl/scsi_xfer_seq.sv
module scsi_xfer_seq
    import scsi_xfer_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int RST_CYC = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid_i,
    input  logic [7:0]       cmd_code_i,
    input  logic [CNT_W-1:0] xfer_len_i,
    input  logic             par_chk_en_i,
    input  logic             rst_irq_dis_i,
    input  logic [2:0]       phase_i,
    input  logic             req_i,
    output logic             ack_o,
    output logic             atn_o,
    output logic             bus_rst_o,
    input  logic [7:0]       dat_i,
    input  logic             dpar_i,
    output logic [7:0]       dat_o,
    output logic             dpar_o,
    output logic             dat_oe_o,
    input  logic [7:0]       tx_dat_i,
    input  logic             tx_empty_i,
    output logic             tx_pop_o,
    output logic [7:0]       rx_dat_o,
    output logic             rx_push_o,
    output logic             irq_svc_o,
    output logic             irq_done_o,
    output logic             irq_rst_o,
    output logic             busy_o,
    output logic [7:0]       cmd_reg_o,
    output logic             par_err_o,
    output logic             illegal_o
);
    localparam int RST_CW = $clog2(RST_CYC + 1);
    localparam logic [RST_CW-1:0] RST_LAST = RST_CW'(RST_CYC - 1);

    state_e            state_q, state_d;
    logic [2:0]        lock_ph_q;
    logic              dma_q, last_q;
    logic [RST_CW-1:0] rst_cnt_q;
    logic              ack_q, atn_q, irq_svc_q, irq_done_q, irq_rst_q;
    logic              par_err_q, illegal_q;
    logic [7:0]        cmd_reg_q, dat_o_q;
    logic              dpar_o_q;

    cmd_kind_e kind;
    logic      dec_dma, par_gen, par_bad, cnt_one, cnt_dec;

    scsi_xfer_decode u_dec (
        .valid_i (cmd_valid_i),
        .code_i  (cmd_code_i),
        .kind_o  (kind),
        .dma_o   (dec_dma)
    );

    scsi_xfer_parity u_par (
        .gen_dat_i (tx_dat_i),
        .gen_par_o (par_gen),
        .chk_dat_i (dat_i),
        .chk_par_i (dpar_i),
        .chk_bad_o (par_bad)
    );

    logic idle_like, do_brst, accept, bad_cmd, is_in, ph_match, byte_go, last_now;

    assign idle_like = (state_q == S_IDLE) || (state_q == S_HOLD_ACK);
    assign do_brst   = (kind == CK_BRST);
    assign accept    = (kind == CK_XFER) && idle_like;
    assign bad_cmd   = cmd_valid_i && !do_brst && !accept;
    assign is_in     = lock_ph_q[0];
    assign ph_match  = (phase_i == lock_ph_q);
    assign byte_go   = (state_q == S_WAIT_REQ) && ph_match && req_i;
    assign last_now  = dma_q ? cnt_one : (is_in ? 1'b1 : tx_empty_i);
    assign cnt_dec   = (state_q == S_SETTLE) && dma_q;

    scsi_xfer_cnt #(.W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (accept),
        .load_val_i (xfer_len_i),
        .dec_i      (cnt_dec),
        .one_o      (cnt_one)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (do_brst) begin
            state_d = S_BUS_RST;
        end else begin
            unique case (state_q)
                S_IDLE, S_HOLD_ACK: if (accept) state_d = S_WAIT_REQ;
                S_WAIT_REQ: begin
                    if (!ph_match)  state_d = S_WAIT_SVC;
                    else if (req_i) state_d = S_SETTLE;
                end
                S_SETTLE:   state_d = S_DRIVE;
                S_DRIVE:    state_d = S_ACK_WAIT;
                S_ACK_WAIT: begin
                    if (!req_i) begin
                        if (!last_q)                state_d = S_WAIT_REQ;
                        else if (lock_ph_q == PH_MIN) state_d = S_HOLD_ACK;
                        else                        state_d = S_WAIT_SVC;
                    end
                end
                S_WAIT_SVC: if (req_i) state_d = S_IDLE;
                S_BUS_RST:  if (rst_cnt_q == RST_LAST) state_d = S_IDLE;
                default:    state_d = S_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // registered outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lock_ph_q  <= PH_DOUT;
            dma_q      <= 1'b0;
            last_q     <= 1'b0;
            rst_cnt_q  <= '0;
            ack_q      <= 1'b0;
            atn_q      <= 1'b0;
            irq_svc_q  <= 1'b0;
            irq_done_q <= 1'b0;
            irq_rst_q  <= 1'b0;
            par_err_q  <= 1'b0;
            illegal_q  <= 1'b0;
            cmd_reg_q  <= 8'h00;
            dat_o_q    <= 8'h00;
            dpar_o_q   <= 1'b0;
        end else if (do_brst) begin
            ack_q      <= 1'b0;
            atn_q      <= 1'b0;
            irq_svc_q  <= 1'b0;
            irq_done_q <= 1'b0;
            irq_rst_q  <= !rst_irq_dis_i;
            cmd_reg_q  <= cmd_code_i;
            rst_cnt_q  <= '0;
        end else begin
            if (bad_cmd) illegal_q <= 1'b1;
            if (accept) begin
                ack_q      <= 1'b0;
                cmd_reg_q  <= cmd_code_i;
                dma_q      <= dec_dma;
                lock_ph_q  <= phase_i;
                atn_q      <= (phase_i == PH_MOUT);
                irq_svc_q  <= 1'b0;
                irq_done_q <= 1'b0;
                irq_rst_q  <= 1'b0;
                par_err_q  <= 1'b0;
                illegal_q  <= 1'b0;
            end
            unique case (state_q)
                S_WAIT_REQ: begin
                    if (!ph_match) begin
                        cmd_reg_q <= 8'h00;
                    end else if (req_i) begin
                        if (!is_in) begin
                            dat_o_q  <= tx_dat_i;
                            dpar_o_q <= par_gen;
                        end else if (par_bad && par_chk_en_i) begin
                            par_err_q <= 1'b1;
                            if (lock_ph_q == PH_DIN) atn_q <= 1'b1;
                        end
                    end
                end
                S_SETTLE: begin
                    last_q <= last_now;
                    if (last_now && lock_ph_q == PH_MOUT) atn_q <= 1'b0;
                end
                S_DRIVE: ack_q <= 1'b1;
                S_ACK_WAIT: begin
                    if (!req_i) begin
                        if (last_q && lock_ph_q == PH_MIN) begin
                            irq_done_q <= 1'b1;
                            cmd_reg_q  <= 8'h00;
                        end else begin
                            ack_q <= 1'b0;
                        end
                    end
                end
                S_WAIT_SVC: begin
                    if (req_i) begin
                        irq_svc_q <= 1'b1;
                        cmd_reg_q <= 8'h00;
                    end
                end
                S_BUS_RST: begin
                    rst_cnt_q <= rst_cnt_q + RST_CW'(1);
                    if (rst_cnt_q == RST_LAST) cmd_reg_q <= 8'h00;
                end
                S_IDLE, S_HOLD_ACK: ;
                default: ;
            endcase
        end
    end

    assign ack_o      = ack_q;
    assign atn_o      = atn_q;
    assign bus_rst_o  = (state_q == S_BUS_RST);
    assign dat_o      = dat_o_q;
    assign dpar_o     = dpar_o_q;
    assign dat_oe_o   = !is_in && ((state_q == S_SETTLE) || (state_q == S_DRIVE) ||
                                   (state_q == S_ACK_WAIT));
    assign tx_pop_o   = byte_go && !is_in;
    assign rx_push_o  = byte_go && is_in;
    assign rx_dat_o   = dat_i;
    assign irq_svc_o  = irq_svc_q;
    assign irq_done_o = irq_done_q;
    assign irq_rst_o  = irq_rst_q;
    assign busy_o     = !idle_like;
    assign cmd_reg_o  = cmd_reg_q;
    assign par_err_o  = par_err_q;
    assign illegal_o  = illegal_q;

endmodule

// File: rtl/scsi_xfer_seq_chk.sv
module scsi_xfer_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_valid_i,
    input logic [7:0] cmd_code_i,
    input logic       req_i,
    input logic       ack_o,
    input logic       atn_o,
    input logic       bus_rst_o,
    input logic       irq_svc_o,
    input logic       irq_done_o,
    input logic       busy_o,
    input logic       illegal_o
);
    // R2: ACK is only released once REQ has been seen low (or on abort/command release)
    a_r2_ack_falls_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ack_o) |-> (!$past(req_i) || bus_rst_o || $past(cmd_valid_i)));

    // R7: ATN never falls in a cycle where ACK is already up
    a_r7_atn_before_ack: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(atn_o) && !bus_rst_o) |-> !ack_o);

    // R10: bus reset drive keeps ACK and ATN released
    a_r10_rst_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rst_o |-> (!ack_o && !atn_o));

    // R11: a non-reset command while busy flags illegal
    a_r11_busy_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_i && busy_o && cmd_code_i[6:0] != 7'h03) |=> illegal_o);

    // R8: the two completion interrupts never coexist
    a_r8_irq_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({irq_svc_o, irq_done_o}));

endmodule

bind scsi_xfer_seq scsi_xfer_seq_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid_i (cmd_valid_i),
    .cmd_code_i  (cmd_code_i),
    .req_i       (req_i),
    .ack_o       (ack_o),
    .atn_o       (atn_o),
    .bus_rst_o   (bus_rst_o),
    .irq_svc_o   (irq_svc_o),
    .irq_done_o  (irq_done_o),
    .busy_o      (busy_o),
    .illegal_o   (illegal_o)
);

// File: tb/scsi_xfer_seq_tb.sv
module scsi_xfer_seq_tb_top;
    localparam int CNT_W   = 16;
    localparam int RST_CYC = 8;

    localparam logic [2:0] P_DOUT = 3'b000, P_DIN = 3'b001, P_STAT = 3'b011,
                           P_MOUT = 3'b110, P_MIN = 3'b111;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic             rst_n = 1'b0;
    logic             cmd_valid = 1'b0;
    logic [7:0]       cmd_code = 8'h00;
    logic [CNT_W-1:0] xfer_len = '0;
    logic             par_chk_en = 1'b0, rst_irq_dis = 1'b0;
    logic [2:0]       phase = P_DOUT;
    logic             req = 1'b0;
    logic             ack, atn, bus_rst;
    logic [7:0]       dat_in = 8'h00;
    logic             dpar_in = 1'b0;
    logic [7:0]       dat_out;
    logic             dpar_out, dat_oe;
    logic [7:0]       tx_dat;
    logic             tx_empty, tx_pop;
    logic [7:0]       rx_dat;
    logic             rx_push;
    logic             irq_svc, irq_done, irq_rst, busy, par_err, illegal;
    logic [7:0]       cmd_reg;

    scsi_xfer_seq #(.CNT_W(CNT_W), .RST_CYC(RST_CYC)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid_i(cmd_valid), .cmd_code_i(cmd_code),
        .xfer_len_i(xfer_len), .par_chk_en_i(par_chk_en), .rst_irq_dis_i(rst_irq_dis),
        .phase_i(phase), .req_i(req), .ack_o(ack), .atn_o(atn), .bus_rst_o(bus_rst),
        .dat_i(dat_in), .dpar_i(dpar_in), .dat_o(dat_out), .dpar_o(dpar_out),
        .dat_oe_o(dat_oe), .tx_dat_i(tx_dat), .tx_empty_i(tx_empty), .tx_pop_o(tx_pop),
        .rx_dat_o(rx_dat), .rx_push_o(rx_push), .irq_svc_o(irq_svc),
        .irq_done_o(irq_done), .irq_rst_o(irq_rst), .busy_o(busy),
        .cmd_reg_o(cmd_reg), .par_err_o(par_err), .illegal_o(illegal)
    );

    // queue models
    logic [7:0] txm [0:15];
    int txh = 0, txt = 0;
    assign tx_empty = (txh == txt);
    assign tx_dat   = txm[txh[3:0]];
    always @(posedge clk) if (tx_pop) txh <= txh + 1;

    logic [7:0] rxm [0:31];
    int rxn = 0;
    always @(posedge clk) if (rx_push) begin rxm[rxn[4:0]] <= rx_dat; rxn <= rxn + 1; end

    int n_chk = 0, n_err = 0;
    logic [7:0] got_d;
    logic got_p, got_atn, prev_atn, got_oe;

    task automatic chk_eq(string rq, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic tx_put(logic [7:0] d);
        txm[txt[3:0]] = d;
        txt++;
    endtask

    task automatic issue(logic [7:0] code, int len);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_code = code; xfer_len = CNT_W'(len);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_ack(logic v, string rq);
        for (int i = 0; i < 40 && ack != v; i++) @(negedge clk);
        chk_eq(rq, "ack level", ack, v);
    endtask

    task automatic tgt_in(logic [7:0] d, logic badp, logic hold, string rq);
        @(negedge clk);
        dat_in = d; dpar_in = (~(^d)) ^ badp; req = 1'b1;
        wait_ack(1'b1, rq);
        got_atn = atn;
        @(negedge clk);
        req = 1'b0;
        if (!hold) wait_ack(1'b0, rq);
    endtask

    task automatic tgt_out(string rq);
        @(negedge clk);
        req = 1'b1;
        prev_atn = atn;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (ack) break;
            prev_atn = atn;
        end
        got_d = dat_out; got_p = dpar_out; got_atn = atn; got_oe = dat_oe;
        req = 1'b0;
        wait_ack(1'b0, rq);
    endtask

    task automatic svc_req(logic [2:0] ph, string rq);
        @(negedge clk);
        phase = ph; req = 1'b1;
        repeat (3) @(negedge clk);
        chk_eq(rq, "irq_svc after REQ", irq_svc, 1);
        req = 1'b0;
        @(negedge clk);
        chk_eq(rq, "busy after svc", busy, 0);
    endtask

    task automatic t_reset();
        chk_eq("R1", "ack", ack, 0);
        chk_eq("R1", "atn", atn, 0);
        chk_eq("R1", "bus_rst", bus_rst, 0);
        chk_eq("R1", "irqs", {irq_svc, irq_done, irq_rst}, 0);
        chk_eq("R1", "status", {par_err, illegal, busy}, 0);
        chk_eq("R1", "cmd_reg", cmd_reg, 0);
    endtask

    task automatic t_dma_in();
        int base = rxn;
        phase = P_DIN;
        issue(8'h90, 3);
        chk_eq("R3", "busy after start", busy, 1);
        tgt_in(8'hA5, 1'b0, 1'b0, "R2");
        tgt_in(8'h3C, 1'b0, 1'b0, "R2");
        chk_eq("R3", "busy before last", busy, 1);
        tgt_in(8'h01, 1'b0, 1'b0, "R2");
        chk_eq("R2", "rx count", rxn - base, 3);
        chk_eq("R2", "rx byte0", rxm[base[4:0]], 8'hA5);
        chk_eq("R2", "rx byte2", rxm[5'(base + 2)], 8'h01);
        chk_eq("R3", "no svc before REQ", irq_svc, 0);
        svc_req(P_STAT, "R3");
    endtask

    task automatic t_nodma_out();
        tx_put(8'h81); tx_put(8'h7E);
        phase = P_DOUT;
        issue(8'h10, 0);
        tgt_out("R2");
        chk_eq("R2", "out byte0", got_d, 8'h81);
        chk_eq("R2", "oe while ack", got_oe, 1);
        chk_eq("R4", "parity byte0", {7'b0, ^{got_d, got_p}}, 1);
        tgt_out("R2");
        chk_eq("R2", "out byte1", got_d, 8'h7E);
        chk_eq("R4", "parity byte1", {7'b0, ^{got_d, got_p}}, 1);
        chk_eq("R3", "queue drained", tx_empty, 1);
        svc_req(P_STAT, "R3");
    endtask

    task automatic t_msgout();
        tx_put(8'h06); tx_put(8'hC0);
        phase = P_MOUT;
        issue(8'h90, 2);
        chk_eq("R7", "atn raised at start", atn, 1);
        tgt_out("R7");
        chk_eq("R7", "atn on first byte", got_atn, 1);
        tgt_out("R7");
        chk_eq("R7", "atn low before last ack", prev_atn, 0);
        chk_eq("R7", "atn low at last ack", got_atn, 0);
        chk_eq("R2", "last msg byte", got_d, 8'hC0);
        svc_req(P_MIN, "R7");
    endtask

    task automatic t_msgin();
        int base = rxn;
        phase = P_MIN;
        issue(8'h10, 0);
        tgt_in(8'h04, 1'b0, 1'b1, "R8");
        repeat (2) @(negedge clk);
        chk_eq("R8", "ack held", ack, 1);
        chk_eq("R8", "irq_done", irq_done, 1);
        chk_eq("R8", "no svc", irq_svc, 0);
        chk_eq("R8", "not busy", busy, 0);
        chk_eq("R8", "byte received", rxm[base[4:0]], 8'h04);
        phase = P_STAT;
        issue(8'h10, 0);
        chk_eq("R8", "ack released by command", ack, 0);
        chk_eq("R12", "done cleared", irq_done, 0);
        tgt_in(8'h00, 1'b0, 1'b0, "R3");
        svc_req(P_MIN, "R3");
    endtask

    task automatic t_parity();
        par_chk_en = 1'b1;
        phase = P_DIN;
        issue(8'h90, 2);
        tgt_in(8'h55, 1'b1, 1'b0, "R6");
        chk_eq("R6", "atn before ack release", got_atn, 1);
        chk_eq("R5", "par_err set", par_err, 1);
        tgt_in(8'h12, 1'b0, 1'b0, "R5");
        chk_eq("R5", "par_err sticky", par_err, 1);
        svc_req(P_STAT, "R5");
        par_chk_en = 1'b0;
        phase = P_DIN;
        issue(8'h10, 0);
        chk_eq("R12", "par_err cleared", par_err, 0);
        tgt_in(8'h55, 1'b1, 1'b0, "R5");
        chk_eq("R5", "no par_err when disabled", par_err, 0);
        chk_eq("R5", "no atn when disabled", got_atn, 0);
        svc_req(P_STAT, "R5");
    endtask

    task automatic t_phase_chg();
        int base = rxn;
        phase = P_DIN;
        issue(8'h90, 3);
        tgt_in(8'h11, 1'b0, 1'b0, "R9");
        @(negedge clk);
        phase = P_STAT;
        repeat (2) @(negedge clk);
        chk_eq("R9", "cmd_reg cleared", cmd_reg, 0);
        chk_eq("R9", "svc waits for REQ", irq_svc, 0);
        chk_eq("R9", "still busy", busy, 1);
        dat_in = 8'hEE;
        svc_req(P_STAT, "R9");
        chk_eq("R9", "no extra byte", rxn - base, 1);
    endtask

    task automatic t_illegal();
        int base = rxn;
        phase = P_DIN;
        issue(8'h90, 2);
        issue(8'h10, 5);
        chk_eq("R11", "illegal set", illegal, 1);
        chk_eq("R11", "cmd_reg kept", cmd_reg, 8'h90);
        tgt_in(8'h21, 1'b0, 1'b0, "R11");
        tgt_in(8'h22, 1'b0, 1'b0, "R11");
        chk_eq("R11", "count unchanged", rxn - base, 2);
        svc_req(P_STAT, "R11");
        phase = P_DIN;
        issue(8'h10, 0);
        chk_eq("R12", "illegal cleared", illegal, 0);
        chk_eq("R12", "svc cleared", irq_svc, 0);
        tgt_in(8'h30, 1'b0, 1'b0, "R3");
        svc_req(P_STAT, "R3");
        issue(8'h55, 0);
        chk_eq("R11", "unknown code", illegal, 1);
        chk_eq("R11", "unknown not started", busy, 0);
    endtask

    task automatic t_bus_rst();
        int cnt = 0;
        tx_put(8'h0F); tx_put(8'hF0);
        phase = P_MOUT;
        issue(8'h90, 2);
        @(negedge clk);
        req = 1'b1;
        wait_ack(1'b1, "R10");
        issue(8'h03, 0);
        chk_eq("R10", "ack dropped", ack, 0);
        chk_eq("R10", "atn dropped", atn, 0);
        chk_eq("R10", "irq_rst", irq_rst, 1);
        while (bus_rst && cnt < 100) begin cnt++; @(negedge clk); end
        chk_eq("R10", "reset length", cnt, RST_CYC);
        chk_eq("R10", "idle after reset", busy, 0);
        req = 1'b0;
        rst_irq_dis = 1'b1;
        issue(8'h83, 0);
        chk_eq("R10", "irq suppressed", irq_rst, 0);
        chk_eq("R10", "bus_rst on 83h", bus_rst, 1);
        repeat (RST_CYC + 2) @(negedge clk);
        chk_eq("R10", "bus_rst ended", bus_rst, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_dma_in();
        t_nodma_out();
        t_msgout();
        t_msgin();
        t_parity();
        t_phase_chg();
        t_illegal();
        t_bus_rst();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule